// File: doc/BRIEF.md
# Four-Bit Lookahead Carry Group Adder

This block is a purely combinational binary adder. Inside each 4-bit slice, every carry comes straight from a flat sum-of-products over the per-bit generate and propagate terms and the slice's incoming carry, so no carry ripples within a slice. Slices are then chained: the carry leaving one slice is the carry entering the next, up to the full word width.

Each slice also reports a slice-level generate term and a slice-level propagate term. A later lookahead level can use these without changing the adder. A build-time option picks the propagate term the carry logic uses: the exclusive-OR of the operand bits, or their inclusive-OR. The sum bits always use the exclusive-OR form.

Top module: `cla_chain_adder`

## Requirements
- R1: For the default 32-bit width, `sum_out` equals `(a_in + b_in + carry_in) mod 2^32` and `carry_out` equals bit 32 of that total, for any operands.
- R2: For all 512 combinations of two 4-bit operands and a carry-in, the 4-bit sum and the carry leaving the slice equal the arithmetic total.
- R3: When every bit pair of the word differs (`a_in ^ b_in` all ones) and `carry_in` is 1, the carry passes the whole word. `sum_out` is all zeros and `carry_out` is 1. With `carry_in` 0, `sum_out` is all ones and `carry_out` is 0.
- R4: `grp_gen_out[k]` is 1 exactly when the slice-k operand nibbles (bits 4k+3..4k) sum to more than 15, which is the slice's carry-out with a carry-in of 0.
- R5: `grp_gen_out[k] | grp_prop_out[k]` is 1 exactly when the slice-k operand nibbles sum to 15 or more, which is the slice's carry-out with a carry-in of 1.
- R6: With exclusive-OR propagate (`OR_PROP` = 0), `grp_prop_out[k]` is 1 exactly when the two slice-k nibbles differ in all four bits. `grp_prop_out[k]` and `grp_gen_out[k]` are then never both 1.
- R7: With inclusive-OR propagate (`OR_PROP` = 1), sum and carry-out are identical to the arithmetic total, so the sum still uses exclusive-OR propagate.
- R8: A carry produced in slice k reaches slice k+1. Adding 1 to an operand whose low 4(k+1) bits are all ones clears those bits and sets bit 4(k+1), or sets `carry_out` when that bit lies past the top of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the lowest slice |
| sum_out | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the top slice |
| grp_prop_out | output | WIDTH/4 | Per-slice propagate term |
| grp_gen_out | output | WIDTH/4 | Per-slice generate term |

## Verification
The hardest case is a carry that has to cross every slice of the full word. Random operands almost never have all 32 bit pairs differing together with a set carry-in. The bench therefore drives that all-propagate pattern directly, using several operand splits. It also drives staircase operands whose low slices are all ones, so that a carry arises in each slice in turn and has to enter the next. Exhaustive nibble sweeps on both propagate variants cover every combination of the slice-level generate and propagate outputs.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned SLICE_BITS = 4;

    // Per-bit terms consumed by a lookahead slice
    typedef struct packed {
        logic [SLICE_BITS-1:0] gen;    // both operand bits set
        logic [SLICE_BITS-1:0] xprop;  // operand bits differ (sum path)
        logic [SLICE_BITS-1:0] cprop;  // propagate used by carry equations
    } slice_terms_t;

    // Everything a slice produces
    typedef struct packed {
        logic [SLICE_BITS-1:0] sum;
        logic [SLICE_BITS-1:0] carry;  // carry out of each bit position
        logic                  blk_gen;
        logic                  blk_prop;
    } slice_res_t;

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms
    import cla_pkg::*;
#(
    parameter bit OR_PROP = 1'b0
) (
    input  logic [SLICE_BITS-1:0] a_nib,
    input  logic [SLICE_BITS-1:0] b_nib,
    output slice_terms_t          terms
);

    for (genvar i = 0; i < SLICE_BITS; i++) begin : g_bit
        assign terms.gen[i]   = a_nib[i] & b_nib[i];
        assign terms.xprop[i] = a_nib[i] ^ b_nib[i];
        if (OR_PROP) begin : g_or
            assign terms.cprop[i] = a_nib[i] | b_nib[i];
        end else begin : g_xor
            assign terms.cprop[i] = a_nib[i] ^ b_nib[i];
        end
    end

    // R6: a bit cannot both generate and pass a carry in the differing sense
    always_comb begin
        p_gen_xprop_disjoint_r6: assert ((terms.gen & terms.xprop) == '0)
            else $error("generate and xor-propagate overlap");
    end

endmodule

// File: rtl/cla_slice4.sv
module cla_slice4
    import cla_pkg::*;
#(
    parameter bit OR_PROP = 1'b0
) (
    input  slice_terms_t terms,
    input  logic         cin,
    output slice_res_t   res
);

    logic [3:0] g;
    logic [3:0] p;
    logic [3:0] x;

    assign g = terms.gen;
    assign p = terms.cprop;
    assign x = terms.xprop;

    always_comb begin
        res = '0;
        // flat carry equations, no ripple inside the slice
        res.carry[0] = g[0] | (p[0] & cin);
        res.carry[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
        res.carry[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                     | (p[2] & p[1] & p[0] & cin);
        res.carry[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                     | (p[3] & p[2] & p[1] & g[0])
                     | (p[3] & p[2] & p[1] & p[0] & cin);
        // sum always uses the differing-bits propagate
        res.sum[0] = x[0] ^ cin;
        res.sum[1] = x[1] ^ res.carry[0];
        res.sum[2] = x[2] ^ res.carry[1];
        res.sum[3] = x[3] ^ res.carry[2];
        // slice-level terms: carry-out with cin forced to 0, and full pass
        res.blk_gen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                     | (p[3] & p[2] & p[1] & g[0]);
        res.blk_prop = &p;
    end

    always_comb begin
        // R5: slice carry-out follows the block terms
        p_blk_cout_r5: assert (res.carry[3] == (res.blk_gen | (res.blk_prop & cin)))
            else $error("slice carry-out disagrees with block terms");
        // R3: a fully differing slice hands its carry-in straight through
        p_pass_through_r3: assert (!(&x) || (res.carry[3] == cin))
            else $error("all-propagate slice did not pass carry");
    end

    if (!OR_PROP) begin : g_xor_chk
        always_comb begin
            p_gen_prop_excl_r6: assert (!(res.blk_gen && res.blk_prop))
                else $error("block generate and propagate both set");
        end
    end

endmodule

// File: rtl/cla_chain_adder.sv
module cla_chain_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          OR_PROP = 1'b0
) (
    input  logic [WIDTH-1:0]            a_in,
    input  logic [WIDTH-1:0]            b_in,
    input  logic                        carry_in,
    output logic [WIDTH-1:0]            sum_out,
    output logic                        carry_out,
    output logic [WIDTH/SLICE_BITS-1:0] grp_prop_out,
    output logic [WIDTH/SLICE_BITS-1:0] grp_gen_out
);

    localparam int unsigned NSLICE = WIDTH / SLICE_BITS;

    if ((WIDTH % SLICE_BITS) != 0 || WIDTH < SLICE_BITS) begin : g_bad_width
        $error("WIDTH must be a positive multiple of 4");
    end

    logic [NSLICE:0] link;   // link[k] is the carry into slice k

    assign link[0] = carry_in;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        slice_terms_t terms;
        slice_res_t   res;

        cla_bit_terms #(.OR_PROP(OR_PROP)) u_terms (
            .a_nib (a_in[k*SLICE_BITS +: SLICE_BITS]),
            .b_nib (b_in[k*SLICE_BITS +: SLICE_BITS]),
            .terms (terms)
        );

        cla_slice4 #(.OR_PROP(OR_PROP)) u_slice (
            .terms (terms),
            .cin   (link[k]),
            .res   (res)
        );

        assign sum_out[k*SLICE_BITS +: SLICE_BITS] = res.sum;
        assign link[k+1]       = res.carry[SLICE_BITS-1];
        assign grp_prop_out[k] = res.blk_prop;
        assign grp_gen_out[k]  = res.blk_gen;
    end

    assign carry_out = link[NSLICE];

    // R1: whole word matches the arithmetic total
    always_comb begin
        p_word_total_r1: assert ({carry_out, sum_out}
                                 == ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
            else $error("word sum mismatch");
    end

endmodule

// File: tb/cla_chain_adder_test.sv
module cla_chain_adder_test;

    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
    logic [W/4-1:0] gp, gg;

    logic [3:0] na, nb;
    logic       nci;
    logic [3:0] ns;
    logic       nco;
    logic [0:0] ngp, ngg;

    cla_chain_adder #(.WIDTH(W), .OR_PROP(1'b0)) uut (
        .a_in(a), .b_in(b), .carry_in(ci),
        .sum_out(s), .carry_out(co),
        .grp_prop_out(gp), .grp_gen_out(gg)
    );

    cla_chain_adder #(.WIDTH(4), .OR_PROP(1'b1)) uut_or (
        .a_in(na), .b_in(nb), .carry_in(nci),
        .sum_out(ns), .carry_out(nco),
        .grp_prop_out(ngp), .grp_gen_out(ngg)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic word_case(input logic [W-1:0] x, input logic [W-1:0] y,
                             input logic c, input string req);
        logic [W:0] tot;
        a = x; b = y; ci = c;
        #2;
        tot = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        check({co, s} == tot, req, {31'd0, co, s}, {31'd0, tot});
    endtask

    logic [31:0] rng = 32'h1234_5678;
    function automatic logic [31:0] next_rand(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        na = '0; nb = '0; nci = 1'b0;
        @(negedge clk);
        // R1: quiescent zero inputs
        check(s == '0 && co == 1'b0, "R1 zero", {31'd0, co, s}, 64'd0);
        check(gg == '0 && gp == '0, "R4 zero-inputs group terms", {gp, gg}, 64'd0);

        // R2 R4 R5 R6: exhaustive nibble sweep on slice 0, XOR variant
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] t;
                    a = W'(i); b = W'(j); ci = c[0];
                    #2;
                    t = 5'(i) + 5'(j) + 5'(c);
                    check(s[4:0] == t && s[W-1:5] == '0 && co == 1'b0,
                          "R2 xor nibble", {32'd0, s}, {59'd0, t});
                    check(gg[0] == ((i + j) > 15), "R4 xor group gen",
                          {63'd0, gg[0]}, {63'd0, ((i + j) > 15)});
                    check((gg[0] | gp[0]) == ((i + j) >= 15), "R5 xor gen|prop",
                          {63'd0, gg[0] | gp[0]}, {63'd0, ((i + j) >= 15)});
                    check(gp[0] == ((i ^ j) == 15) && !(gp[0] && gg[0]),
                          "R6 xor group prop", {62'd0, gp[0], gg[0]},
                          {63'd0, ((i ^ j) == 15)});
                end
            end
        end

        // R2 R4 R5 R7: exhaustive sweep on inclusive-OR propagate variant
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] t;
                    na = 4'(i); nb = 4'(j); nci = c[0];
                    #2;
                    t = 5'(i) + 5'(j) + 5'(c);
                    check({nco, ns} == t, "R7 or-prop nibble sum",
                          {59'd0, nco, ns}, {59'd0, t});
                    check(ngg[0] == ((i + j) > 15), "R4 or-prop group gen",
                          {63'd0, ngg[0]}, {63'd0, ((i + j) > 15)});
                    check((ngg[0] | ngp[0]) == ((i + j) >= 15), "R5 or-prop gen|prop",
                          {63'd0, ngg[0] | ngp[0]}, {63'd0, ((i + j) >= 15)});
                end
            end
        end

        // R3: all-propagate across the whole word, several splits
        word_case(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R3 all-prop ones/zeros cin1");
        word_case(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1, "R3 all-prop mixed cin1");
        word_case(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1, "R3 all-prop nibbles cin1");
        word_case(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0, "R3 all-prop mixed cin0");
        a = 32'h3C3C_C3C3; b = 32'hC3C3_3C3C; ci = 1'b1;
        #2;
        check(s == '0 && co == 1'b1, "R3 full-chain carry", {31'd0, co, s}, {31'd0, 1'b1, 32'd0});
        check(gp == '1 && gg == '0, "R6 all-prop group terms", {gp, gg}, {8'hFF, 8'h00});

        // R8: carry created in slice k must enter slice k+1
        for (int k = 0; k < W / 4; k++) begin
            logic [W-1:0] ones;
            ones = (k == W / 4 - 1) ? '1 : ((W'(1) << (4 * (k + 1))) - 1);
            word_case(ones, 32'd1, 1'b0, "R8 staircase b=1");
            word_case(ones, 32'd0, 1'b1, "R8 staircase cin=1");
        end

        // R1: pseudo-random full-width operands
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x, y;
            rng = next_rand(rng); x = rng;
            rng = next_rand(rng); y = rng;
            word_case(x, y, rng[7], "R1 random word");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule